// File: doc/BRIEF.md
# Sampled Event Detector with Debounce Window

This block watches an asynchronous event pin and records a sticky event flag when the pin is high. The pin first passes through a two-stage synchronizer. The detector can watch the pin on every clock, or it can look at the pin only at a slow, duty-cycled sample point. A sample point is derived from a 32768 Hz tick enable. In the duty-cycled modes, a qualification window can also be required. The pin must then stay high for the whole window, counted from the sample point, before the event is accepted.

A recorded event does three things:
- It drives an active-low detect output. This output can be held inactive while the system runs from its backup battery.
- It raises a halt request for the timekeeping counters, when that feature is selected.
- It stays recorded until the host pulses a clear input.

Top module: `evd_top`

## Requirements
- R1: With rate code 00 (continuous) and detection enabled, a high level on the pin sets the event flag on the third rising clock edge after the pin changes. In this mode the window code has no effect.
- R2: Rate codes 01, 10 and 11 sample the pin once every TPS/2, TPS and 4*TPS ticks. TPS is the number of ticks per second. The count starts when detection is enabled. A high pulse that falls wholly between two sample points is not recorded.
- R3: Window codes 01, 10 and 11 require the pin to stay high for TPS/256, TPS/64 and TPS/32 ticks after a sample point. If the pin goes low inside the window, that qualification is abandoned.
- R4: In a sampled mode with window code 00, an event is recorded from the sample point alone.
- R5: While the enable input is low, no new event is recorded, and a flag that is already set keeps its value.
- R6: The event flag stays set until the clear input is pulsed. If a new detection and a clear fall in the same cycle, the detection wins.
- R7: The detect output is low exactly when the flag is set. The exception is when both the battery indicator and the battery-quiet configuration bit are high: the output is then high, while the flag stays set.
- R8: The halt request is high exactly when the flag is set and halt-on-event is configured.
- R9: While reset is high, the flag and the halt request are 0 and the detect output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32768 Hz tick enable, one clock wide |
| ev_pin | input | 1 | Asynchronous event pin |
| on_battery | input | 1 | High while running from the backup supply |
| cfg_en | input | 1 | Detection enable |
| cfg_rate | input | 2 | Sampling rate code |
| cfg_win | input | 2 | Qualification window code |
| cfg_bat_quiet | input | 1 | Hold the detect output inactive on battery |
| cfg_halt | input | 1 | Request a timekeeper halt on event |
| evt_clr | input | 1 | Host clear pulse for the flag |
| evt_flag | output | 1 | Sticky event flag |
| det_n | output | 1 | Active-low detect output |
| halt_req | output | 1 | Halt request to the timekeeper |

## Verification
A sample counter on the wrong phase moves the moment the flag rises by whole sample periods. It shows within one period of enabling, which is why the bench checks just before and just after the expected point. A window counter of the wrong length, or one that fails to abort, shows as a flag that rises at the wrong position inside the window or rises after a glitch. Both of these show within a few dozen ticks of the sample point. A flag-hold error shows as a set flag that drops without a clear pulse, on the very next edge.

// File: rtl/evd_pkg.sv
package evd_pkg;

    typedef enum logic [1:0] {
        RATE_CONT = 2'b00,
        RATE_2HZ  = 2'b01,
        RATE_1HZ  = 2'b10,
        RATE_QHZ  = 2'b11
    } evd_rate_e;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'b00,
        WIN_SHORT = 2'b01,
        WIN_MID   = 2'b10,
        WIN_LONG  = 2'b11
    } evd_win_e;

    typedef struct packed {
        logic      en;
        evd_rate_e rate;
        evd_win_e  win;
        logic      bat_quiet;
        logic      halt_en;
    } evd_cfg_t;

    typedef enum logic {
        Q_IDLE = 1'b0,
        Q_HOLD = 1'b1
    } evd_qual_e;

    // Ticks between sample points for a rate code.
    function automatic int unsigned sample_period(evd_rate_e r, int unsigned tps);
        case (r)
            RATE_2HZ: return tps / 2;
            RATE_1HZ: return tps;
            RATE_QHZ: return 4 * tps;
            default:  return 1;
        endcase
    endfunction

    // Ticks the pin must stay high for a window code.
    function automatic int unsigned window_len(evd_win_e w, int unsigned tps);
        case (w)
            WIN_SHORT: return tps / 256;
            WIN_MID:   return tps / 64;
            WIN_LONG:  return tps / 32;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/evd_sync.sv
module evd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/evd_sampler.sv
module evd_sampler
    import evd_pkg::*;
#(
    parameter int unsigned TPS = 32768
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      run,
    input  evd_rate_e rate,
    output logic      strobe
);
    localparam int unsigned MAXP = 4 * TPS;
    localparam int unsigned CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb last = CW'(sample_period(rate, TPS) - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (tick) begin
            if (cnt == last) begin
                cnt    <= '0;
                strobe <= 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
                strobe <= 1'b0;
            end
        end else begin
            strobe <= 1'b0;
        end
    end

    // R2: a sample point only follows a cycle in which sampling was running
    p_strobe_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(run));

    // R2: sample points are isolated pulses (periods are longer than one tick)
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/evd_qualifier.sv
module evd_qualifier
    import evd_pkg::*;
#(
    parameter int unsigned TPS = 32768
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     armed,
    input  logic     strobe,
    input  logic     pin_s,
    input  evd_win_e win,
    output logic     hit
);
    localparam int unsigned WMAX = TPS / 32;
    localparam int unsigned WW   = $clog2(WMAX + 1);

    evd_qual_e     st;
    logic [WW-1:0] cnt;
    logic [WW-1:0] last;

    always_comb last = WW'(window_len(win, TPS) - 1);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            st  <= Q_IDLE;
            cnt <= '0;
            hit <= 1'b0;
        end else begin
            hit <= 1'b0;
            case (st)
                Q_IDLE: begin
                    if (strobe && pin_s) begin
                        if (win == WIN_NONE) begin
                            hit <= 1'b1;
                        end else begin
                            st  <= Q_HOLD;
                            cnt <= '0;
                        end
                    end
                end
                default: begin
                    if (!pin_s) begin
                        st <= Q_IDLE;
                    end else if (tick) begin
                        if (cnt == last) begin
                            hit <= 1'b1;
                            st  <= Q_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R3: a qualified hit needs the synchronized pin high in the previous cycle
    p_hit_needs_pin_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(pin_s));

    // R3: a low pin during the window abandons it
    p_abort_low_r3: assert property (@(posedge clk) disable iff (rst)
        (st == Q_HOLD && !pin_s) |=> (st == Q_IDLE && !hit));
endmodule

// File: rtl/evd_top.sv
module evd_top
    import evd_pkg::*;
#(
    parameter int unsigned TPS = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ev_pin,
    input  logic       on_battery,
    input  logic       cfg_en,
    input  logic [1:0] cfg_rate,
    input  logic [1:0] cfg_win,
    input  logic       cfg_bat_quiet,
    input  logic       cfg_halt,
    input  logic       evt_clr,
    output logic       evt_flag,
    output logic       det_n,
    output logic       halt_req
);
    evd_cfg_t cfg;
    logic     pin_s;
    logic     armed;
    logic     strobe;
    logic     qual_hit;
    logic     detect;

    always_comb begin
        cfg.en        = cfg_en;
        cfg.rate      = evd_rate_e'(cfg_rate);
        cfg.win       = evd_win_e'(cfg_win);
        cfg.bat_quiet = cfg_bat_quiet;
        cfg.halt_en   = cfg_halt;
    end

    evd_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ev_pin),
        .q   (pin_s)
    );

    assign armed = cfg.en && (cfg.rate != RATE_CONT);

    evd_sampler #(.TPS(TPS)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (armed),
        .rate   (cfg.rate),
        .strobe (strobe)
    );

    evd_qualifier #(.TPS(TPS)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .armed  (armed),
        .strobe (strobe),
        .pin_s  (pin_s),
        .win    (cfg.win),
        .hit    (qual_hit)
    );

    always_comb begin
        if (!cfg.en)                     detect = 1'b0;
        else if (cfg.rate == RATE_CONT)  detect = pin_s;
        else                             detect = qual_hit;
    end

    always_ff @(posedge clk) begin
        if (rst)          evt_flag <= 1'b0;
        else if (detect)  evt_flag <= 1'b1;
        else if (evt_clr) evt_flag <= 1'b0;
    end

    assign det_n    = !(evt_flag && !(on_battery && cfg.bat_quiet));
    assign halt_req = evt_flag && cfg.halt_en;

    // R6: a set flag is only dropped by a clear pulse
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !evt_clr) |=> evt_flag);

    // R5: nothing new is recorded while disabled
    p_no_new_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !evt_flag) |=> !evt_flag);

    // R7: battery-quiet keeps the detect output inactive
    p_quiet_on_battery_r7: assert property (@(posedge clk) disable iff (rst)
        (on_battery && cfg_bat_quiet) |-> det_n);

    // R9: reset clears the flag
    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> !evt_flag);
endmodule

// File: tb/sim_evd_top.sv
`timescale 1ns/1ps
module sim_evd_top;
    localparam int unsigned TPS = 1024;

    logic       clk = 1'b0;
    logic       rst, tick, ev_pin, on_battery, cfg_en, cfg_bat_quiet, cfg_halt, evt_clr;
    logic [1:0] cfg_rate, cfg_win;
    logic       evt_flag, det_n, halt_req;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    evd_top #(.TPS(TPS)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .ev_pin(ev_pin), .on_battery(on_battery),
        .cfg_en(cfg_en), .cfg_rate(cfg_rate), .cfg_win(cfg_win),
        .cfg_bat_quiet(cfg_bat_quiet), .cfg_halt(cfg_halt), .evt_clr(evt_clr),
        .evt_flag(evt_flag), .det_n(det_n), .halt_req(halt_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wipe();
        cfg_en = 1'b0; ev_pin = 1'b0; evt_clr = 1'b1;
        clocks(1);
        evt_clr = 1'b0;
        clocks(3);
    endtask

    task automatic t_reset();
        chk("R9", "flag in reset", evt_flag, 1'b0);
        chk("R9", "det_n in reset", det_n, 1'b1);
        chk("R9", "halt in reset", halt_req, 1'b0);
    endtask

    task automatic t_continuous();
        wipe();
        cfg_rate = 2'b00; cfg_win = 2'b11; cfg_en = 1'b1;
        clocks(2);
        ev_pin = 1'b1;
        clocks(2);
        chk("R1", "flag before sync delay", evt_flag, 1'b0);
        clocks(1);
        chk("R1", "flag on third edge, window ignored", evt_flag, 1'b1);
        chk("R7", "det_n low with flag", det_n, 1'b0);
    endtask

    task automatic t_sticky();
        ev_pin = 1'b0;
        clocks(10);
        chk("R6", "flag holds after pin low", evt_flag, 1'b1);
        ev_pin = 1'b1;
        clocks(3);
        evt_clr = 1'b1;
        clocks(1);
        evt_clr = 1'b0;
        chk("R6", "detection beats clear", evt_flag, 1'b1);
        ev_pin = 1'b0;
        clocks(3);
        evt_clr = 1'b1;
        clocks(1);
        evt_clr = 1'b0;
        chk("R6", "clear drops flag", evt_flag, 1'b0);
    endtask

    task automatic t_disabled();
        wipe();
        cfg_rate = 2'b00; cfg_en = 1'b0; ev_pin = 1'b1;
        clocks(20);
        chk("R5", "no event while disabled", evt_flag, 1'b0);
        cfg_en = 1'b1;
        clocks(3);
        cfg_en = 1'b0; ev_pin = 1'b0;
        clocks(20);
        chk("R5", "flag kept while disabled", evt_flag, 1'b1);
    endtask

    task automatic t_rate(input logic [1:0] code, input int per);
        wipe();
        cfg_rate = code; cfg_win = 2'b00; ev_pin = 1'b1;
        clocks(3);
        cfg_en = 1'b1;
        clocks(per - 5);
        chk("R2", "no event before sample point", evt_flag, 1'b0);
        clocks(15);
        chk("R4", "event at sample point, no window", evt_flag, 1'b1);
    endtask

    task automatic t_between();
        wipe();
        cfg_rate = 2'b01; cfg_win = 2'b00; cfg_en = 1'b1;
        clocks(100);
        ev_pin = 1'b1;
        clocks(50);
        ev_pin = 1'b0;
        clocks(500);
        chk("R2", "pulse between samples ignored", evt_flag, 1'b0);
    endtask

    task automatic t_window(input logic [1:0] code, input logic exp524);
        wipe();
        cfg_rate = 2'b01; cfg_win = code; ev_pin = 1'b1;
        clocks(3);
        cfg_en = 1'b1;
        clocks(524);
        chk("R3", "flag early in window", evt_flag, exp524);
        clocks(12);
        chk("R3", "flag after window", evt_flag, 1'b1);
    endtask

    task automatic t_abort();
        wipe();
        cfg_rate = 2'b01; cfg_win = 2'b11; ev_pin = 1'b1;
        clocks(3);
        cfg_en = 1'b1;
        clocks(515);
        ev_pin = 1'b0;
        clocks(10);
        ev_pin = 1'b1;
        clocks(35);
        chk("R3", "glitch in window aborts", evt_flag, 1'b0);
        clocks(514);
        chk("R3", "next sample qualifies", evt_flag, 1'b1);
    endtask

    task automatic t_outputs();
        on_battery = 1'b1; cfg_bat_quiet = 1'b1;
        clocks(1);
        chk("R7", "det_n quiet on battery", det_n, 1'b1);
        chk("R7", "flag still set on battery", evt_flag, 1'b1);
        cfg_bat_quiet = 1'b0;
        clocks(1);
        chk("R7", "det_n active on battery", det_n, 1'b0);
        on_battery = 1'b0; cfg_bat_quiet = 1'b1;
        clocks(1);
        chk("R7", "det_n active off battery", det_n, 1'b0);
        cfg_halt = 1'b1;
        clocks(1);
        chk("R8", "halt with flag", halt_req, 1'b1);
        cfg_halt = 1'b0;
        clocks(1);
        chk("R8", "no halt when not configured", halt_req, 1'b0);
        cfg_halt = 1'b1;
        wipe();
        chk("R8", "no halt without flag", halt_req, 1'b0);
        cfg_halt = 1'b0;
    endtask

    initial begin
        rst = 1'b1; tick = 1'b1; ev_pin = 1'b0; on_battery = 1'b0; cfg_en = 1'b0;
        cfg_rate = 2'b00; cfg_win = 2'b00; cfg_bat_quiet = 1'b0; cfg_halt = 1'b0; evt_clr = 1'b0;
        clocks(3);
        t_reset();
        rst = 1'b0;
        clocks(1);
        t_continuous();
        t_sticky();
        t_disabled();
        t_rate(2'b01, TPS / 2);
        t_rate(2'b10, TPS);
        t_rate(2'b11, 4 * TPS);
        t_between();
        t_window(2'b01, 1'b1);
        t_window(2'b10, 1'b0);
        t_abort();
        t_outputs();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule